// File: doc/BRIEF.md
# Two-Wire Clock Waveform Generator

This block produces the serial clock for a two-wire bus master. A system clock is divided into a high phase and a low phase of programmable length. The bus engine next to it uses two kinds of strobe to place its transitions. The boundary strobes mark the first cycle of each phase. The mid-phase strobes mark the point where SDA is sampled or where a start or stop is placed (high phase), and the point where SDA may change (low phase).

A 19-bit divider word sets the timing. It has an 8-bit divisor for the high phase, a separate 8-bit divisor for the low phase, and a 3-bit prescaler exponent. A phase lasts `divisor * 2^exponent + OFFSET` system clocks. OFFSET is a fixed per-variant parameter. Exponents above the variant's maximum are clamped to that maximum. A new divider word is staged when written and is only adopted at a phase boundary, so a running phase is never stretched or cut. When the block is disabled it releases SCL high and clears its counters. When enabled it begins with a complete high phase.

Top module: `scl_wavegen`

## Requirements
- R1: While reset is asserted, and until the block is enabled, `scl_o` is 1 and all four strobes are 0.
- R2: Divider word fields are: low-phase divisor in bits 7:0, high-phase divisor in bits 15:8, exponent in bits 18:16. The high phase lasts hi*2^e + OFFSET cycles and the low phase lasts lo*2^e + OFFSET cycles, so unequal divisors give an asymmetric waveform.
- R3: An exponent field larger than MAX_EXP behaves exactly as MAX_EXP.
- R4: `scl_rise_stb` is 1 only in the first cycle of each high phase and `scl_fall_stb` only in the first cycle of each low phase. `scl_o` toggles at every phase end.
- R5: `scl_hmid_stb` and `scl_lmid_stb` are 1 in cycle floor(L/2) of a high or low phase of length L, counting that phase's first cycle as 0.
- R6: At most one strobe is 1 in any cycle.
- R7: A divider write made before the final cycle of a phase leaves that phase's length unchanged. The write governs every phase from the next boundary onwards.
- R8: A divider write made in the final cycle of a phase already governs the phase that follows it.
- R9: Deasserting `enable` drives `scl_o` to 1 and silences the strobes from the next cycle. Reasserting it starts a full high phase, whose rise strobe appears in the cycle after the enabling edge.
- R10: A divisor of 0 gives a phase of exactly OFFSET cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enable | input | 1 | Runs the waveform when 1; holds SCL released when 0 |
| cfg_we | input | 1 | Write strobe for the divider word |
| cfg_wdata | input | 19 | Divider word {exponent[2:0], high divisor[7:0], low divisor[7:0]} |
| scl_o | output | 1 | SCL level (1 = released) |
| scl_rise_stb | output | 1 | First cycle of a high phase |
| scl_fall_stb | output | 1 | First cycle of a low phase |
| scl_hmid_stb | output | 1 | Middle of the high phase |
| scl_lmid_stb | output | 1 | Middle of the low phase |

## Verification
A divider write and a phase-end reload can land in the same cycle. The bench provokes this by raising `cfg_we` in exactly the last cycle of a high phase. It judges the result by timing the strobes of the following low phase, which must already use the new low divisor. A disable and a pending mid-phase strobe also meet when `enable` drops just after a fall strobe. The bench checks that SCL returns high in the next cycle and that the low-phase strobe never appears.

// File: rtl/scl_wavegen_pkg.sv
package scl_wavegen_pkg;
  localparam int DIV_W  = 8;
  localparam int EXP_W  = 3;
  localparam int WORD_W = EXP_W + 2 * DIV_W;

  // field order is fixed by the software-visible divider word
  typedef struct packed {
    logic [EXP_W-1:0] exp;
    logic [DIV_W-1:0] hi;
    logic [DIV_W-1:0] lo;
  } div_word_t;

  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } phase_e;
endpackage

// File: rtl/scl_rst_sync.sv
module scl_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/scl_cfg_stage.sv
module scl_cfg_stage
  import scl_wavegen_pkg::*;
#(
  parameter int MAX_EXP = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  div_word_t        wr_word,
  input  logic             run_q,
  input  logic             at_end,
  output logic [DIV_W-1:0] hi_div,
  output logic [DIV_W-1:0] lo_div,
  output logic [EXP_W-1:0] exp_eff
);
  div_word_t pend_q, pend_d;
  div_word_t act_q, act_d;
  logic      load;

  always_comb begin
    pend_d = wr_en ? wr_word : pend_q;
    // reload only while idle or on the last cycle of a phase; a write
    // arriving in that same cycle is forwarded straight in
    load   = !run_q || at_end;
    act_d  = load ? pend_d : act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      pend_q <= pend_d;
      act_q  <= act_d;
    end
  end

  assign hi_div = act_q.hi;
  assign lo_div = act_q.lo;

  generate
    if (MAX_EXP >= (2 ** EXP_W) - 1) begin : g_no_clamp
      assign exp_eff = act_q.exp;
    end else begin : g_clamp
      assign exp_eff = (act_q.exp > EXP_W'(MAX_EXP)) ? EXP_W'(MAX_EXP) : act_q.exp;
    end
  endgenerate

  // R7: active word never changes inside a running phase
  p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !at_end) |=> $stable(act_q));
endmodule

// File: rtl/scl_phase_timer.sv
module scl_phase_timer
  import scl_wavegen_pkg::*;
#(
  parameter int OFFSET  = 3,
  parameter int MAX_EXP = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             run_q,
  input  logic             phase_hi,
  input  logic [DIV_W-1:0] hi_div,
  input  logic [DIV_W-1:0] lo_div,
  input  logic [EXP_W-1:0] exp_eff,
  output logic             at_start,
  output logic             at_mid,
  output logic             at_end
);
  localparam int LEN_W = DIV_W + MAX_EXP + 2;

  logic [DIV_W-1:0] div_sel;
  logic [LEN_W-1:0] len;
  logic [LEN_W-1:0] cnt_q, cnt_d;

  always_comb begin
    div_sel  = phase_hi ? hi_div : lo_div;
    len      = (LEN_W'(div_sel) << exp_eff) + LEN_W'(OFFSET);
    at_start = run_q && (cnt_q == '0);
    at_mid   = run_q && (cnt_q == (len >> 1));
    at_end   = run_q && (cnt_q == len - LEN_W'(1));
    if (!enable || !run_q || at_end) cnt_d = '0;
    else                             cnt_d = cnt_q + LEN_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2: position inside the phase never passes the programmed length
  p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q < len));

  // R5: the midpoint strobe falls strictly before the phase end
  p_mid_before_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    at_mid |-> !at_end);
endmodule

// File: rtl/scl_phase_ctrl.sv
module scl_phase_ctrl
  import scl_wavegen_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic at_start,
  input  logic at_mid,
  input  logic at_end,
  output logic run_q,
  output logic phase_hi,
  output logic scl_o,
  output logic rise_stb,
  output logic fall_stb,
  output logic hmid_stb,
  output logic lmid_stb
);
  phase_e ph_q, ph_d;
  logic   run_d;

  always_comb begin
    run_d = enable;
    if (!enable || !run_q) ph_d = PH_HIGH;
    else if (at_end)       ph_d = (ph_q == PH_HIGH) ? PH_LOW : PH_HIGH;
    else                   ph_d = ph_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      ph_q  <= PH_HIGH;
    end else begin
      run_q <= run_d;
      ph_q  <= ph_d;
    end
  end

  assign phase_hi = (ph_q == PH_HIGH);
  assign scl_o    = phase_hi;
  assign rise_stb = at_start &&  phase_hi;
  assign fall_stb = at_start && !phase_hi;
  assign hmid_stb = at_mid   &&  phase_hi;
  assign lmid_stb = at_mid   && !phase_hi;

  // R6: strobes are mutually exclusive
  p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise_stb, fall_stb, hmid_stb, lmid_stb}));

  // R4: level flips at every phase end
  p_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && at_end) |=> (scl_o != $past(scl_o)));

  // R9: enabling opens with a high phase
  p_launch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !run_q) |=> rise_stb);
endmodule

// File: rtl/scl_wavegen.sv
module scl_wavegen
  import scl_wavegen_pkg::*;
#(
  parameter int OFFSET  = 3,
  parameter int MAX_EXP = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              cfg_we,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic              scl_o,
  output logic              scl_rise_stb,
  output logic              scl_fall_stb,
  output logic              scl_hmid_stb,
  output logic              scl_lmid_stb
);
  logic             rst_n_s;
  logic             run_q, phase_hi;
  logic             at_start, at_mid, at_end;
  logic [DIV_W-1:0] hi_div, lo_div;
  logic [EXP_W-1:0] exp_eff;

  scl_rst_sync u_rst (
    .clk      (clk),
    .rst_n_in (rst_n),
    .rst_n_out(rst_n_s)
  );

  scl_cfg_stage #(.MAX_EXP(MAX_EXP)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .wr_en  (cfg_we),
    .wr_word(div_word_t'(cfg_wdata)),
    .run_q  (run_q),
    .at_end (at_end),
    .hi_div (hi_div),
    .lo_div (lo_div),
    .exp_eff(exp_eff)
  );

  scl_phase_timer #(.OFFSET(OFFSET), .MAX_EXP(MAX_EXP)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .enable  (enable),
    .run_q   (run_q),
    .phase_hi(phase_hi),
    .hi_div  (hi_div),
    .lo_div  (lo_div),
    .exp_eff (exp_eff),
    .at_start(at_start),
    .at_mid  (at_mid),
    .at_end  (at_end)
  );

  scl_phase_ctrl u_ctl (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .enable  (enable),
    .at_start(at_start),
    .at_mid  (at_mid),
    .at_end  (at_end),
    .run_q   (run_q),
    .phase_hi(phase_hi),
    .scl_o   (scl_o),
    .rise_stb(scl_rise_stb),
    .fall_stb(scl_fall_stb),
    .hmid_stb(scl_hmid_stb),
    .lmid_stb(scl_lmid_stb)
  );

  // R9: disabled block releases the line and stays silent
  p_idle_high_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    !enable |=> (scl_o && !(scl_rise_stb || scl_fall_stb || scl_hmid_stb || scl_lmid_stb)));
endmodule

// File: tb/scl_wavegen_tb.sv
`timescale 1ns/1ps
module scl_wavegen_tb;
  localparam int OFFS = 3;
  localparam int MAXE = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        cfg_we = 1'b0;
  logic [18:0] cfg_wdata = '0;
  logic        scl_o, rise, fall, hmid, lmid;

  always #2.5 clk = ~clk;

  scl_wavegen #(.OFFSET(OFFS), .MAX_EXP(MAXE)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .scl_o(scl_o), .scl_rise_stb(rise), .scl_fall_stb(fall),
    .scl_hmid_stb(hmid), .scl_lmid_stb(lmid)
  );

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int kind; int at; bit lvl; string req; } ev_t;
  ev_t sb[$];
  string kname[4] = '{"rise", "hmid", "fall", "lmid"};

  task automatic chk(bit ok, string msg);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s", msg);
    end
  endtask

  function automatic int plen(int dv, int ex);
    int e = (ex > MAXE) ? MAXE : ex;
    return (dv << e) + OFFS;
  endfunction

  task automatic push_phase(int t, int len, bit hi, string req);
    ev_t e;
    e.kind = hi ? 0 : 2; e.at = t;           e.lvl = hi; e.req = {req, ",R4"}; sb.push_back(e);
    e.kind = hi ? 1 : 3; e.at = t + len / 2; e.lvl = hi; e.req = {req, ",R5"}; sb.push_back(e);
  endtask

  task automatic push_periods(int t, int lh, int ll, int n, string req);
    for (int p = 0; p < n; p++) begin
      push_phase(t, lh, 1'b1, req);
      push_phase(t + lh, ll, 1'b0, req);
      t += lh + ll;
    end
  endtask

  task automatic set_word(int hi, int lo, int ex);
    cfg_wdata = {3'(ex), 8'(hi), 8'(lo)};
  endtask

  task automatic write_at(int c, int hi, int lo, int ex);
    while (cyc != c) @(negedge clk);
    cfg_we = 1'b1;
    set_word(hi, lo, ex);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic write_idle(int hi, int lo, int ex);
    @(negedge clk);
    cfg_we = 1'b1;
    set_word(hi, lo, ex);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic start(output int t0);
    @(negedge clk);
    enable = 1'b1;
    t0 = cyc + 1;
  endtask

  task automatic drain_stop(string req);
    while (sb.size() != 0) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    chk(scl_o === 1'b1, $sformatf("%s R9 scl after disable act=%0b exp=1", req, scl_o));
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    logic [3:0] s;
    ev_t e;
    s = {lmid, fall, hmid, rise};
    if (s != 4'b0) begin
      chk($countones(s) == 1, $sformatf("R6 strobes act=%b exp=one-hot", s));
      for (int k = 0; k < 4; k++) begin
        if (s[k]) begin
          if (sb.size() == 0) begin
            chk(1'b0, $sformatf("R9 unexpected %s at cycle %0d act=strobe exp=none",
                                kname[k], cyc));
          end else begin
            e = sb.pop_front();
            chk(e.kind == k && e.at == cyc && e.lvl == scl_o,
                $sformatf("%s act=%s@%0d scl=%0b exp=%s@%0d scl=%0b", e.req,
                          kname[k], cyc, scl_o, kname[e.kind], e.at, e.lvl));
          end
        end
      end
    end
    if (sb.size() != 0 && cyc > sb[0].at) begin
      e = sb.pop_front();
      chk(1'b0, $sformatf("%s missing act=none exp=%s@%0d", e.req, kname[e.kind], e.at));
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog act=hung exp=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int t0;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(scl_o === 1'b1 && {rise, fall, hmid, lmid} === 4'b0,
        $sformatf("R1 in reset act=%0b%b exp=1/0000", scl_o, {rise, fall, hmid, lmid}));
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(scl_o === 1'b1 && {rise, fall, hmid, lmid} === 4'b0,
        $sformatf("R1 idle after reset act=%0b%b exp=1/0000", scl_o, {rise, fall, hmid, lmid}));

    // R2: asymmetric divisors with exponent 1
    write_idle(2, 5, 1);
    start(t0);
    push_periods(t0, plen(2, 1), plen(5, 1), 3, "R2");
    drain_stop("R2");

    // R10: zero divisors give OFFSET cycles
    write_idle(0, 0, 3);
    start(t0);
    push_periods(t0, OFFS, OFFS, 4, "R10");
    drain_stop("R10");

    // R3: exponent above the maximum is clamped
    write_idle(1, 2, 7);
    start(t0);
    push_periods(t0, plen(1, MAXE), plen(2, MAXE), 1, "R3");
    drain_stop("R3");
    write_idle(3, 1, 6);
    start(t0);
    push_periods(t0, plen(3, MAXE), plen(1, MAXE), 1, "R3");
    drain_stop("R3");

    // R7: write in the middle of a high phase
    write_idle(4, 3, 0);
    start(t0);
    push_phase(t0, plen(4, 0), 1'b1, "R7");
    push_phase(t0 + 7, plen(9, 0), 1'b0, "R7");
    push_periods(t0 + 7 + 12, plen(6, 0), plen(9, 0), 1, "R7");
    write_at(t0 + 2, 6, 9, 0);
    drain_stop("R7");

    // R8: write in the last cycle of a high phase
    write_idle(2, 2, 0);
    start(t0);
    push_phase(t0, 5, 1'b1, "R8");
    push_phase(t0 + 5, plen(7, 1), 1'b0, "R8");
    push_periods(t0 + 5 + 17, plen(0, 1), plen(7, 1), 1, "R8");
    write_at(t0 + 4, 0, 7, 1);
    drain_stop("R8");

    // R9: disable early in a low phase, then restart
    write_idle(1, 10, 0);
    start(t0);
    push_phase(t0, plen(1, 0), 1'b1, "R9");
    begin
      ev_t e;
      e.kind = 2; e.at = t0 + 4; e.lvl = 1'b0; e.req = "R9,R4";
      sb.push_back(e);
    end
    drain_stop("R9");
    repeat (3) begin
      @(negedge clk);
      chk(scl_o === 1'b1, $sformatf("R9 held high while disabled act=%0b exp=1", scl_o));
    end
    start(t0);
    push_periods(t0, plen(1, 0), plen(10, 0), 2, "R9");
    drain_stop("R9");

    // R2 boundary: largest divisor, top exponent
    write_idle(255, 0, 5);
    start(t0);
    push_periods(t0, plen(255, 5), plen(0, 5), 1, "R2");
    drain_stop("R2");

    repeat (4) @(negedge clk);
    chk(sb.size() == 0, $sformatf("R4 leftover events act=%0d exp=0", sb.size()));
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule